// File: doc/BRIEF.md
# Programmable Local Countdown Timer

The block is a countdown timer for one processor's local interrupt controller. Software programs a start count, a clock divider and a timer vector entry through a simple register port. The timer then counts bus-clock cycles, one per `clk_i` cycle, scaled by the divider. Each time the count runs out, a pending count goes up by one. While the controller is enabled and the timer entry is unmasked, each pending expiry is offered to the interrupt arbiter as a vector on a valid/ready handshake.

The timer runs once and stops, or it reloads and runs again. In periodic mode a very short period is raised to a minimum so that the interrupt rate stays bounded. A software-disable write masks every local vector entry and drops pending expiries. The current count can be read back at any time.

Top module: `loc_timer`

## Requirements
- R1: The divide register (address 3, bits 3:0) sets the scale. The 3-bit code {bit3, bit1, bit0} plus one, modulo 8, is an exponent e, and the ratio is 2^e. So 0x0 divides by 2, 0x3 divides by 16, 0x8 divides by 32 and 0xB divides by 1.
- R2: A write to the start-count register (address 1) drops any running count and starts again from the new value. The same write clears the pending count.
- R3: A start count of zero leaves the timer stopped. It produces no expiry, and the current count (address 2) reads 0.
- R4: The period is P = start × ratio cycles. One cycle after the start write, the current count reads (P−1)/ratio, and it falls by one tick every cycle. In one-shot mode exactly one expiry happens, P cycles after the write, and the counter then stops at 0.
- R5: In periodic mode (timer entry bit 17 set) the counter reloads on each expiry, so expiries come every P cycles. A nonzero P below MIN_PERIOD (default 64) is raised to MIN_PERIOD.
- R6: `irq_valid_o` is high only while `hw_en_i` is high, the software enable bit (address 0, bit 8) is set, the timer entry mask (address 4, bit 16) is clear, and the pending count is nonzero. `irq_vector_o` is timer entry bits 7:0. Each handshake (valid and ready together) takes one from the pending count.
- R7: Writing address 0 with bit 8 clear sets the mask bit (bit 16) in all six local vector entries (addresses 4 to 9) and clears the pending count. While software is disabled, any entry write is stored with the mask set.
- R8: A write to the timer entry keeps only bits 7:0 (vector), 12 (status), 16 (mask) and 17 (periodic). All other bits read back as 0.
- R9: After reset, address 0 reads 0x0FF, all six entries read 0x00010000, and the start count, divide register and current count read 0. `irq_valid_o` is low.
- R10: The pending count saturates at 255 and does not wrap. After 255 or more undelivered expiries, exactly 255 deliveries follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | Controller globally enabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_valid_o | output | 1 | Timer interrupt offered to the arbiter |
| irq_vector_o | output | 8 | Offered vector |
| irq_ready_i | input | 1 | Arbiter accepts the offer |

## Verification
The assertions check these rules on every cycle:
- the cycle-by-cycle decrement of the remaining ticks;
- the stop that follows a zero start count;
- periodic continuation after an expiry;
- the handshake decrement and the saturation hold of the pending count;
- the all-entries masking that follows a software-disable write.

Only the bench scenarios can show the rest:
- the exact cycle at which each delivery appears, for each divider code and for the clamped periodic case;
- the current-count readings;
- the field filtering on entry writes;
- the exact number of deliveries that drain from a saturated pending count.

// File: rtl/loc_timer_pkg.sv
package loc_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SVR  = 4'd0;
  localparam logic [ADDR_W-1:0] A_INIT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CUR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd3;
  localparam logic [ADDR_W-1:0] A_LVT0 = 4'd4;

  localparam int SW_EN_BIT = 8;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;
  localparam int VEC_W     = 8;

  localparam logic [DATA_W-1:0] TMR_KEEP = 32'h0003_10FF;
  localparam logic [DATA_W-1:0] LVT_KEEP = 32'h0001_F7FF;
  localparam logic [DATA_W-1:0] LVT_RST  = 32'h0001_0000;
  localparam logic [8:0]        SVR_RST  = 9'h0FF;

  // exponent = {d3,d1,d0} + 1, wrapping in 3 bits
  function automatic logic [2:0] div_shift(input logic [3:0] d);
    return {d[3], d[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/loc_timer_regs.sv
module loc_timer_regs import loc_timer_pkg::*; #(
  parameter int NUM_LVT = 6,
  parameter int COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [8:0]         svr_o,
  output logic               sw_en_o,
  output logic [COUNT_W-1:0] init_o,
  output logic [3:0]         div_o,
  output logic [DATA_W-1:0]  lvt_o [NUM_LVT],
  output logic               init_wr_o,
  output logic               sw_off_o
);
  logic [8:0]         svr_q;
  logic [COUNT_W-1:0] init_q;
  logic [3:0]         div_q;

  assign sw_off_o  = wr_en_i && (wr_addr_i == A_SVR) && !wr_data_i[SW_EN_BIT];
  assign init_wr_o = wr_en_i && (wr_addr_i == A_INIT);
  assign sw_en_o   = svr_q[SW_EN_BIT];
  assign svr_o     = svr_q;
  assign init_o    = init_q;
  assign div_o     = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svr_q  <= SVR_RST;
      init_q <= '0;
      div_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_SVR) svr_q  <= wr_data_i[8:0];
      if (wr_addr_i == A_INIT) init_q <= wr_data_i[COUNT_W-1:0];
      if (wr_addr_i == A_DIV) div_q  <= wr_data_i[3:0];
    end
  end

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_lvt
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_LVT0 + i);
    localparam logic [DATA_W-1:0] KEEP = (i == 0) ? TMR_KEEP : LVT_KEEP;
    logic [DATA_W-1:0] lvt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvt_q <= LVT_RST;
      end else if (sw_off_o) begin
        lvt_q[MASK_BIT] <= 1'b1;
      end else if (wr_en_i && (wr_addr_i == MY_A)) begin
        lvt_q <= (wr_data_i | (sw_en_o ? '0 : LVT_RST)) & KEEP;
      end
    end
    assign lvt_o[i] = lvt_q;
  end
endmodule

// File: rtl/loc_timer_count.sv
module loc_timer_count #(
  parameter int COUNT_W    = 32,
  parameter int MIN_PERIOD = 64,
  localparam int PER_W     = COUNT_W + 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [COUNT_W-1:0] init_i,
  input  logic [2:0]         shift_i,
  input  logic               periodic_i,
  output logic               expire_o,
  output logic               running_o,
  output logic [PER_W-1:0]   rem_o,
  output logic [COUNT_W-1:0] cur_o
);
  logic [PER_W-1:0] scaled, period_nxt, period_q, rem_q;
  logic             run_q;

  always_comb begin
    scaled     = PER_W'(init_i) << shift_i;
    period_nxt = scaled;
    if (periodic_i && (scaled != '0) && (scaled < PER_W'(MIN_PERIOD)))
      period_nxt = PER_W'(MIN_PERIOD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      rem_q    <= '0;
      run_q    <= 1'b0;
    end else if (ld_i) begin
      period_q <= period_nxt;
      run_q    <= (period_nxt != '0);
      rem_q    <= (period_nxt != '0) ? period_nxt - 1'b1 : '0;
    end else if (run_q) begin
      if (rem_q == '0) begin
        if (periodic_i) rem_q <= period_q - 1'b1;
        else            run_q <= 1'b0;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign expire_o  = run_q && (rem_q == '0) && !ld_i;
  assign running_o = run_q;
  assign rem_o     = rem_q;
  assign cur_o     = COUNT_W'(rem_q >> shift_i);
endmodule

// File: rtl/loc_timer_pend.sv
module loc_timer_pend #(
  parameter int PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              clr_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q;
  logic              inc_eff;

  assign inc_eff = inc_i && (pend_q != '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= '0;
    else if (clr_i)             pend_q <= '0;
    else if (inc_eff && !dec_i) pend_q <= pend_q + 1'b1;
    else if (!inc_eff && dec_i) pend_q <= pend_q - 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/loc_timer.sv
module loc_timer import loc_timer_pkg::*; #(
  parameter int NUM_LVT    = 6,
  parameter int COUNT_W    = 32,
  parameter int MIN_PERIOD = 64,
  parameter int PEND_W     = 8,
  localparam int PER_W     = COUNT_W + 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_valid_o,
  output logic [VEC_W-1:0]  irq_vector_o,
  input  logic              irq_ready_i
);
  logic [8:0]         svr;
  logic               sw_en, init_wr, sw_off, clr;
  logic [COUNT_W-1:0] init_val, cur;
  logic [3:0]         div_val;
  logic [DATA_W-1:0]  lvt [NUM_LVT];
  logic [NUM_LVT-1:0] lvt_masks;
  logic               expire, running, handshake, tmr_periodic;
  logic [PER_W-1:0]   rem;
  logic [PEND_W-1:0]  pend_q;

  loc_timer_regs #(.NUM_LVT(NUM_LVT), .COUNT_W(COUNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .svr_o(svr), .sw_en_o(sw_en), .init_o(init_val), .div_o(div_val),
    .lvt_o(lvt), .init_wr_o(init_wr), .sw_off_o(sw_off)
  );

  assign tmr_periodic = lvt[0][PER_BIT];

  loc_timer_count #(.COUNT_W(COUNT_W), .MIN_PERIOD(MIN_PERIOD)) u_count (
    .clk_i, .rst_ni,
    .ld_i(init_wr), .init_i(wr_data_i[COUNT_W-1:0]),
    .shift_i(div_shift(div_val)), .periodic_i(tmr_periodic),
    .expire_o(expire), .running_o(running), .rem_o(rem), .cur_o(cur)
  );

  assign clr = sw_off || init_wr;

  loc_timer_pend #(.PEND_W(PEND_W)) u_pend (
    .clk_i, .rst_ni, .inc_i(expire), .dec_i(handshake), .clr_i(clr), .pend_o(pend_q)
  );

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_mask
    assign lvt_masks[i] = lvt[i][MASK_BIT];
  end

  assign irq_valid_o  = hw_en_i && sw_en && !lvt[0][MASK_BIT] && (pend_q != '0);
  assign irq_vector_o = lvt[0][VEC_W-1:0];
  assign handshake    = irq_valid_o && irq_ready_i;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_SVR:   rd_data_o = DATA_W'(svr);
      A_INIT:  rd_data_o = DATA_W'(init_val);
      A_CUR:   rd_data_o = DATA_W'(cur);
      A_DIV:   rd_data_o = DATA_W'(div_val);
      default: begin
        for (int i = 0; i < NUM_LVT; i++)
          if (rd_addr_i == ADDR_W'(A_LVT0 + i)) rd_data_o = lvt[i];
      end
    endcase
  end
endmodule

// File: rtl/loc_timer_chk.sv
module loc_timer_chk #(
  parameter int NUM_LVT = 6,
  parameter int COUNT_W = 32,
  parameter int PEND_W  = 8,
  parameter int PER_W   = 39
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [3:0]         wr_addr_i,
  input logic [31:0]        wr_data_i,
  input logic               irq_valid_o,
  input logic               irq_ready_i,
  input logic [PEND_W-1:0]  pend_q,
  input logic               expire,
  input logic               clr,
  input logic               init_wr,
  input logic               running,
  input logic [PER_W-1:0]   rem,
  input logic               tmr_periodic,
  input logic [NUM_LVT-1:0] lvt_masks
);
  // R4
  tick_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && (rem != '0) && !init_wr |=> rem == $past(rem) - 1'b1);

  // R3
  zero_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr && (wr_data_i[COUNT_W-1:0] == '0) |=> !running && (rem == '0));

  // R5
  periodic_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && tmr_periodic |=> running);

  // R6
  deliver_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_ready_i && !expire && !clr |=> pend_q == $past(pend_q) - 1'b1);

  // R7
  sw_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i == 4'd0) && !wr_data_i[8] |=> (&lvt_masks) && (pend_q == '0));

  // R10
  pend_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '1) && !(irq_valid_o && irq_ready_i) && !clr |=> pend_q == '1);
endmodule

bind loc_timer loc_timer_chk #(
  .NUM_LVT(NUM_LVT), .COUNT_W(COUNT_W), .PEND_W(PEND_W), .PER_W(PER_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .irq_valid_o(irq_valid_o), .irq_ready_i(irq_ready_i),
  .pend_q(pend_q), .expire(expire), .clr(clr), .init_wr(init_wr),
  .running(running), .rem(rem), .tmr_periodic(tmr_periodic), .lvt_masks(lvt_masks)
);

// File: tb/tb_loc_timer.sv
module tb_loc_timer;
  logic        clk_i = 1'b0, rst_ni = 1'b0, hw_en_i = 1'b1, wr_en_i = 1'b0, irq_ready_i = 1'b1;
  logic [3:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic        irq_valid_o;
  logic [7:0]  irq_vector_o;

  loc_timer dut (.*);

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] vec; int at; } exp_t;
  exp_t exq[$];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic push(input logic [7:0] v, input int at);
    exp_t e;
    e.vec = v; e.at = at;
    exq.push_back(e);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk_i);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected deliveries on each handshake
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && irq_valid_o && irq_ready_i) begin
      if (exq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 unexpected delivery actual=%0h expected=none", irq_vector_o);
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk("R6", "delivered vector", 64'(irq_vector_o), 64'(e.vec));
        if (e.at >= 0) chk("R4", "delivery cycle", 64'(cyc), 64'(e.at));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset values
    rd(4'd0, d); chk("R9", "svr", 64'(d), 64'h0FF);
    for (int i = 0; i < 6; i++) begin
      rd(4'(4 + i), d); chk("R9", "entry", 64'(d), 64'h0001_0000);
    end
    rd(4'd1, d); chk("R9", "init", 64'(d), 0);
    rd(4'd3, d); chk("R9", "div", 64'(d), 0);
    rd(4'd2, d); chk("R9", "cur", 64'(d), 0);
    chk("R9", "valid", 64'(irq_valid_o), 0);

    // R8 field filter on timer entry
    wr(4'd0, 32'h1FF);
    wr(4'd4, 32'hFFFC_FF40);
    rd(4'd4, d); chk("R8", "timer entry", 64'(d), 64'h0000_1040);

    // R4 one-shot, divide by 2
    wr(4'd3, 32'h0);
    wr(4'd1, 32'd100); c0 = cyc;
    push(8'h40, c0 + 200);
    rd(4'd2, d); chk("R4", "cur after load", 64'(d), 99);
    repeat (50) @(negedge clk_i);
    rd(4'd2, d); chk("R4", "cur after 50", 64'(d), 74);
    wait_until(c0 + 450);
    chk("R4", "one-shot queue", 64'(exq.size()), 0);
    rd(4'd2, d); chk("R4", "cur stopped", 64'(d), 0);

    // R1 divide by 1
    wr(4'd3, 32'hB);
    wr(4'd1, 32'd30); c0 = cyc;
    push(8'h40, c0 + 30);
    rd(4'd2, d); chk("R1", "cur div1", 64'(d), 29);
    wait_until(c0 + 40);
    chk("R1", "div1 queue", 64'(exq.size()), 0);

    // R1 divide by 16
    wr(4'd3, 32'h3);
    rd(4'd3, d); chk("R1", "div readback", 64'(d), 3);
    wr(4'd1, 32'd5);
    rd(4'd2, d); chk("R1", "cur div16", 64'(d), 4);

    // R1 divide by 32, then R3 stop by zero
    wr(4'd3, 32'h8);
    wr(4'd1, 32'd10);
    rd(4'd2, d); chk("R1", "cur div32", 64'(d), 9);
    repeat (32) @(negedge clk_i);
    rd(4'd2, d); chk("R1", "cur div32 later", 64'(d), 8);
    wr(4'd1, 32'd0); c0 = cyc;
    rd(4'd2, d); chk("R3", "cur zero start", 64'(d), 0);
    wait_until(c0 + 400);
    chk("R3", "no expiry", 64'(exq.size()), 0);
    chk("R3", "valid", 64'(irq_valid_o), 0);

    // R5 periodic with clamp
    wr(4'd3, 32'hB);
    wr(4'd4, 32'h0002_0041);
    wr(4'd1, 32'd10); c0 = cyc;
    push(8'h41, c0 + 64); push(8'h41, c0 + 128); push(8'h41, c0 + 192);
    rd(4'd2, d); chk("R5", "clamped cur", 64'(d), 63);
    wait_until(c0 + 200);
    wr(4'd1, 32'd0);
    wait_until(c0 + 320);
    chk("R5", "periodic queue", 64'(exq.size()), 0);

    // R2 restart clears pending
    wr(4'd4, 32'h40);
    irq_ready_i = 1'b0;
    wr(4'd1, 32'd30);
    repeat (40) @(negedge clk_i);
    #1 chk("R6", "valid pending", 64'(irq_valid_o), 1);
    wr(4'd1, 32'd50); c0 = cyc;
    #1 chk("R2", "valid after restart", 64'(irq_valid_o), 0);
    rd(4'd2, d); chk("R2", "cur after restart", 64'(d), 49);
    irq_ready_i = 1'b1;
    push(8'h40, c0 + 50);
    wait_until(c0 + 60);
    chk("R2", "restart queue", 64'(exq.size()), 0);

    // R6 gating by hw enable, R7 software disable
    wr(4'd6, 32'h55);
    rd(4'd6, d); chk("R7", "entry2 unmasked", 64'(d), 64'h55);
    irq_ready_i = 1'b0;
    wr(4'd1, 32'd30);
    repeat (40) @(negedge clk_i);
    hw_en_i = 1'b0;
    #1 chk("R6", "valid hw off", 64'(irq_valid_o), 0);
    @(negedge clk_i); hw_en_i = 1'b1;
    #1 chk("R6", "valid hw on", 64'(irq_valid_o), 1);
    wr(4'd0, 32'h0FF);
    #1 chk("R7", "valid after disable", 64'(irq_valid_o), 0);
    for (int i = 0; i < 6; i++) begin
      rd(4'(4 + i), d); chk("R7", "mask set", 64'(d[16]), 1);
    end
    wr(4'd4, 32'h40);
    rd(4'd4, d); chk("R7", "forced mask", 64'(d), 64'h0001_0040);
    wr(4'd0, 32'h1FF);
    wr(4'd4, 32'h40);
    #1 chk("R7", "pending cleared", 64'(irq_valid_o), 0);
    irq_ready_i = 1'b1;

    // R10 saturation
    wr(4'd4, 32'h0003_0042);
    wr(4'd1, 32'd64); c0 = cyc;
    wait_until(c0 + 64 * 260);
    chk("R6", "masked no valid", 64'(irq_valid_o), 0);
    wr(4'd4, 32'h0001_0042);
    repeat (70) @(negedge clk_i);
    for (int i = 0; i < 255; i++) push(8'h42, -1);
    wr(4'd4, 32'h42);
    repeat (300) @(negedge clk_i);
    chk("R10", "saturated drain", 64'(exq.size()), 0);
    #1 chk("R10", "valid after drain", 64'(irq_valid_o), 0);

    finish_sim();
  end
endmodule